// File: doc/BRIEF.md
# Eight-bit ALU with zero flag

This block is the arithmetic and logic unit of a small accumulator-style processor. Each cycle it takes a source byte chosen by the register file, the current value of the accumulator A, and the 11-bit instruction word. The function code in instruction bits 8:6 selects one of eight operations, and the block returns a result byte for the destination register. A write-enable output tells the register file whether that byte should be stored.

A single zero flag is held inside the block. It is updated on each clock edge at which an ALU-class instruction executes, meaning one whose bits 10:9 are 11. Compare is not a separate function. It is the subtract code with destination field 111: the flag is updated, and the write-enable stays low.

To support a single level of call and return, the flag is always visible at an output so that the call logic can keep a copy of it. A restore input loads a saved value back into the flag.

Top module: `alu8_core`

## Requirements
- R1: Function code 000 (add) drives result = (source + A) mod 256, and the carry out is dropped.
- R2: Function code 001 (subtract) drives result = (source − A) mod 256.
- R3: Function code 010 drives result = (source + 1) mod 256, and function code 011 drives result = (source − 1) mod 256. A has no effect on either.
- R4: Function code 100 shifts the source left by one bit, and function code 101 shifts it right by one bit. In both cases the vacated bit is filled with 0.
- R5: Function code 110 drives result = source AND A, bit by bit.
- R6: Function code 111 (move) drives result = source.
- R7: At a clock edge with an ALU-class instruction (bits 10:9 = 11), the flag becomes 1 if the result byte was zero and 0 otherwise.
- R8: Compare (bits 10:9 = 11, bits 8:6 = 001, bits 5:3 = 111) keeps the write-enable low and leaves the flag set exactly when source equals A. Every other ALU-class instruction raises the write-enable.
- R9: An instruction with bits 10:9 other than 11 leaves the flag unchanged and keeps the write-enable low.
- R10: When the restore input is high at a clock edge, the flag takes the restore value. This takes priority over an ALU-class update in the same cycle.
- R11: An active-low reset clears the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 11 | Instruction word; bits 10:9 give the class, 8:6 the function, 5:3 the destination |
| src_i | input | 8 | Selected source byte |
| acc_i | input | 8 | Accumulator A |
| result_o | output | 8 | Result byte for the destination register |
| wr_en_o | output | 1 | Result should be written to the destination |
| zf_o | output | 1 | Zero flag; the call logic reads it to save the flag |
| zf_restore_i | input | 1 | Load the flag from zf_restore_val_i on return |
| zf_restore_val_i | input | 1 | Saved flag value to restore |

## Verification
Every function code is run against all 256 source values, each paired with several accumulator values: 0, 1, 0x7F, 0x80, 0xFF and 0x55. The zero and all-ones accumulators show wrap-around in both directions. The 0x7F and 0x80 values expose a dropped or misplaced carry. The alternating pattern separates AND from move, and it also shows whether the increment and decrement ignore A. Because every source value is used, a zero result appears under every function, so the flag is seen both setting and clearing. Compare is swept with the source equal to A and with it unequal. Separate sequences cover a non-ALU instruction while the flag is 1 and while it is 0, a restore alone, a restore that collides with an ALU update, and a reset applied while the flag is set.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   typedef enum logic [2:0] {
      FN_ADD = 3'b000,
      FN_SUB = 3'b001,
      FN_INC = 3'b010,
      FN_DEC = 3'b011,
      FN_SHL = 3'b100,
      FN_SHR = 3'b101,
      FN_AND = 3'b110,
      FN_MOV = 3'b111
   } alu_fn_e;

   localparam logic [1:0] CLASS_ALU = 2'b11;
   localparam logic [2:0] DST_NONE  = 3'b111;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit SHARED = 1'b1
) (
   input  alu_fn_e        fn,
   input  logic [W-1:0]   src,
   input  logic [W-1:0]   acc,
   output logic [W-1:0]   res
);
   generate
      if (SHARED) begin : g_shared
         // One adder; the second operand and carry-in are steered per function.
         logic [W-1:0] opb;
         logic [W-1:0] cin;
         always_comb begin
            unique case (fn)
               FN_SUB:  begin opb = ~acc; cin = W'(1); end
               FN_INC:  begin opb = '0;   cin = W'(1); end
               FN_DEC:  begin opb = '1;   cin = '0;    end
               default: begin opb = acc;  cin = '0;    end
            endcase
         end
         assign res = src + opb + cin;
      end else begin : g_split
         // Four adders run in parallel and a mux picks one result.
         logic [W-1:0] r_add, r_sub, r_inc, r_dec;
         assign r_add = src + acc;
         assign r_sub = src - acc;
         assign r_inc = src + W'(1);
         assign r_dec = src - W'(1);
         always_comb begin
            unique case (fn)
               FN_SUB:  res = r_sub;
               FN_INC:  res = r_inc;
               FN_DEC:  res = r_dec;
               default: res = r_add;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_fn_e        fn,
   input  logic [W-1:0]   src,
   input  logic [W-1:0]   acc,
   output logic [W-1:0]   res
);
   always_comb begin
      unique case (fn)
         FN_SHL:  res = {src[W-2:0], 1'b0};
         FN_SHR:  res = {1'b0, src[W-1:1]};
         FN_AND:  res = src & acc;
         default: res = src;
      endcase
   end
endmodule

// File: rtl/alu8_zflag.sv
module alu8_zflag (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_en,
   input  logic upd_val,
   input  logic rstr_en,
   input  logic rstr_val,
   output logic zf
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       zf <= 1'b0;
      else if (rstr_en) zf <= rstr_val;
      else if (upd_en)  zf <= upd_val;
   end

   assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rstr_en |=> (zf == $past(rstr_val)));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !rstr_en) |=> $stable(zf));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int INSTR_W      = 11,
   parameter int FN_LSB       = 6,
   parameter int DST_LSB      = 3,
   parameter int CLASS_LSB    = 9,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  src_i,
   input  logic [DATA_W-1:0]  acc_i,
   output logic [DATA_W-1:0]  result_o,
   output logic               wr_en_o,
   output logic               zf_o,
   input  logic               zf_restore_i,
   input  logic               zf_restore_val_i
);
   localparam int FN_W  = 3;
   localparam int CLS_W = 2;

   generate
      if (DATA_W < 2)
         $error("alu8_core: DATA_W must be at least 2");
      if (CLASS_LSB + CLS_W > INSTR_W || FN_LSB + FN_W > INSTR_W || DST_LSB + FN_W > INSTR_W)
         $error("alu8_core: instruction fields exceed INSTR_W");
   endgenerate

   alu_fn_e            fn;
   logic [FN_W-1:0]    dst;
   logic               alu_class, is_cmp;
   logic [DATA_W-1:0]  arith_res, logic_res;

   assign fn        = alu_fn_e'(instr_i[FN_LSB +: FN_W]);
   assign dst       = instr_i[DST_LSB +: FN_W];
   assign alu_class = (instr_i[CLASS_LSB +: CLS_W] == CLASS_ALU);
   assign is_cmp    = alu_class && (fn == FN_SUB) && (dst == DST_NONE);
   assign wr_en_o   = alu_class && !is_cmp;

   alu8_arith #(.W(DATA_W), .SHARED(SHARED_ADDER)) u_arith (
      .fn(fn), .src(src_i), .acc(acc_i), .res(arith_res));

   alu8_logic #(.W(DATA_W)) u_logic (
      .fn(fn), .src(src_i), .acc(acc_i), .res(logic_res));

   // Bit 2 of the function code splits the adder group from the shift/logic group.
   assign result_o = fn[2] ? logic_res : arith_res;

   alu8_zflag u_zflag (
      .clk(clk), .rst_n(rst_n),
      .upd_en(alu_class), .upd_val(result_o == '0),
      .rstr_en(zf_restore_i), .rstr_val(zf_restore_val_i),
      .zf(zf_o));

   logic [DATA_W-1:0] sub_back;
   assign sub_back = result_o + acc_i;

   assert_sub_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == FN_SUB) |-> (sub_back == src_i));

   assert_zf_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_class && !zf_restore_i) |=> (zf_o == ($past(result_o) == '0)));

   assert_cmp_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmp && !zf_restore_i) |=> (zf_o == ($past(src_i) == $past(acc_i))));

   assert_nonalu_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[CLASS_LSB +: CLS_W] != CLASS_ALU) |-> !wr_en_o);
endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] instr = '0;
   logic [7:0]  src = '0, acc = '0;
   logic [7:0]  result;
   logic        wr_en, zf;
   logic        rstr = 1'b0, rstr_val = 1'b0;
   int          errors = 0, checks = 0;

   always #2 clk = ~clk;

   alu8_core u_alu8_core (
      .clk(clk), .rst_n(rst_n), .instr_i(instr), .src_i(src), .acc_i(acc),
      .result_o(result), .wr_en_o(wr_en), .zf_o(zf),
      .zf_restore_i(rstr), .zf_restore_val_i(rstr_val));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int model(input int fn, input int s, input int a);
      case (fn)
         0: return (s + a) & 255;
         1: return (s - a) & 255;
         2: return (s + 1) & 255;
         3: return (s - 1) & 255;
         4: return (s << 1) & 255;
         5: return s >> 1;
         6: return s & a;
         default: return s;
      endcase
   endfunction

   function automatic string req_of(input int fn);
      case (fn)
         0: return "R1";
         1: return "R2";
         2, 3: return "R3";
         4, 5: return "R4";
         6: return "R5";
         default: return "R6";
      endcase
   endfunction

   // Drive after a falling edge, check combinational outputs, then check the flag after the rising edge.
   task automatic apply(input logic [10:0] ins, input int s, input int a,
                        input int exp_res, input int exp_wr, input int exp_zf, input string req);
      @(negedge clk);
      instr = ins; src = 8'(s); acc = 8'(a);
      #1;
      if (exp_res >= 0) check(req, int'(result), exp_res);
      check({req, " wr_en"}, int'(wr_en), exp_wr);
      @(posedge clk);
      #1;
      check({req, " flag"}, int'(zf), exp_zf);
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int accs[6] = '{0, 1, 8'h7F, 8'h80, 8'hFF, 8'h55};
      repeat (3) @(negedge clk);
      check("R11 reset", int'(zf), 0);
      rst_n = 1'b1;

      // R1..R7: every function, all sources, several accumulator values.
      for (int fn = 0; fn < 8; fn++)
         for (int ai = 0; ai < 6; ai++)
            for (int s = 0; s < 256; s++) begin
               int e;
               e = model(fn, s, accs[ai]);
               apply({2'b11, 3'(fn), 3'b010, 3'b001}, s, accs[ai], e, 1, int'(e == 0),
                     {req_of(fn), "/R7"});
            end

      // R8: compare, equal and unequal operands.
      for (int s = 0; s < 256; s += 5) begin
         apply({2'b11, 3'b001, 3'b111, 3'b000}, s, s, -1, 0, 1, "R8 cmp equal");
         apply({2'b11, 3'b001, 3'b111, 3'b000}, s, (s + 3) & 255, -1, 0, 0, "R8 cmp differ");
      end

      // R9: non-ALU instructions leave the flag alone.
      apply({2'b11, 3'b001, 3'b111, 3'b000}, 9, 9, -1, 0, 1, "R8 set flag");
      apply({2'b10, 3'b001, 3'b010, 3'b001}, 4, 1, -1, 0, 1, "R9 hold 1");
      apply({2'b01, 3'b111, 3'b010, 3'b001}, 7, 3, -1, 0, 1, "R9 hold 1 other class");
      apply({2'b11, 3'b111, 3'b010, 3'b001}, 7, 0, 7, 1, 0, "R6 clear flag");
      apply({2'b00, 3'b000, 3'b010, 3'b001}, 0, 0, -1, 0, 0, "R9 hold 0");
      apply({2'b10, 3'b001, 3'b111, 3'b000}, 5, 5, -1, 0, 0, "R9 hold 0 cmp-like");

      // R10: restore alone, and restore colliding with an ALU update.
      rstr = 1'b1; rstr_val = 1'b1;
      apply({2'b01, 3'b100, 3'b000, 3'b000}, 0, 0, -1, 0, 1, "R10 restore 1");
      rstr_val = 1'b0;
      apply({2'b11, 3'b111, 3'b010, 3'b001}, 0, 0, 0, 1, 0, "R10 priority over zero result");
      rstr_val = 1'b1;
      apply({2'b11, 3'b111, 3'b010, 3'b001}, 6, 0, 6, 1, 1, "R10 priority over nonzero");
      rstr = 1'b0; rstr_val = 1'b0;
      apply({2'b01, 3'b000, 3'b000, 3'b000}, 6, 0, -1, 0, 1, "R10 holds after restore");

      // R11: reset while the flag is set.
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R11 async clear", int'(zf), 0);
      @(negedge clk);
      rst_n = 1'b1;
      check("R11 after reset", int'(zf), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule